// File: doc/BRIEF.md
# Unique-Word Deframer with Rotation Correction

A QPSK carrier loop whose error detector has fourfold symmetry can settle at any of four phases 90 degrees apart. Symbol decisions then reach the receiver with an unknown rotation. This block takes those 2-bit decisions and slides an 8-symbol window over them. It compares the window in parallel against the known sync word in each of its four rotated forms. When one form matches exactly, the block records which rotation it was and raises a one-cycle frame-start pulse. It then applies the inverse rotation to each following symbol.

The 84 corrected symbols after the sync word carry 168 payload bits. The block regroups them into 24 characters of 7 bits, each marked by a one-cycle valid strobe. After the last character it returns to searching, so a stream that repeats the packet is resynchronized on every copy. This also covers the case where the loop locks only partway through the first copy.

Top module: `uw_rotation_deframer`

## Requirements
- R1: While reset is low and immediately after it is released, frame_start, char_valid, packet_done, rot_idx and char_data are all zero.
- R2: The sync word in transmission order is the symbol sequence 11,10,10,11,10,01,00,00. When its eighth symbol is accepted (sym_valid high), frame_start is high for exactly one cycle, the cycle after that clock edge, and rot_idx reads 0.
- R3: A rotation step maps each symbol 00→01→11→10→00. A sync word whose every symbol has been stepped k times (k = 0..3) is detected the same way as in R2, and rot_idx then reads k.
- R4: Detection needs all eight window symbols to agree. A sync word with any one symbol altered produces no frame_start.
- R5: After detection, each payload symbol is stepped (4−k) mod 4 times and shifted in high bit first. Characters are assembled MSB first. char_valid pulses for one cycle, carrying char_data, in the cycle after the edge that accepted the symbol holding the character's 7th bit.
- R6: Each frame yields exactly 24 characters. packet_done is high in the same cycle as the 24th char_valid and at no other time.
- R7: A sync word, in any rotation, that appears inside the 84 payload symbols is ignored: there is no frame_start, and character output continues unchanged.
- R8: After a payload ends, the window is empty. A new detection needs eight symbols received after the payload, and a later frame may report a different rotation.
- R9: Cycles with sym_valid low change nothing: no symbol enters the window or the payload, and no strobe is produced.
- R10: rot_idx changes only in a cycle where frame_start is high, and it holds its value across the payload and the search that follows.
- R11: The search slides one symbol at a time, so a sync word preceded by an incomplete copy of itself is still found.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | A symbol decision is present on sym_in this cycle |
| sym_in | input | 2 | QPSK symbol decision (bit pair) |
| frame_start | output | 1 | One-cycle pulse when the sync word is detected |
| rot_idx | output | 2 | Number of rotation steps found at the last detection |
| char_valid | output | 1 | One-cycle strobe marking char_data |
| char_data | output | 7 | Derotated payload character, MSB is the earliest bit |
| packet_done | output | 1 | Pulse accompanying the last character of a frame |

## Verification
The bench drives random symbol noise between frames, with the noise steered away from accidental sync patterns. It covers all four rotations, including frames where the rotation changes from one packet to the next. A sync word with one corrupted symbol checks exact matching; a tolerant comparator would start a spurious frame. A sync word planted inside a payload checks that detection is suppressed during the payload; a design that restarted there would cut the character stream short. A payload whose last symbol is the first sync symbol, followed by the remaining seven, checks the window flush; a design that kept stale symbols would start a frame one symbol early. Random gaps in sym_valid would show up as duplicated or shifted characters in a design that counted cycles instead of accepted symbols.

// File: rtl/uwdf_pkg.sv
package uwdf_pkg;

  localparam int SYM_W = 2;

  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_PAYLOAD = 2'd1,
    ST_RESYNC  = 2'd2
  } uwdf_state_t;

  // One 90-degree step along the Gray cycle 00 -> 01 -> 11 -> 10 -> 00
  function automatic logic [SYM_W-1:0] rot_step(input logic [SYM_W-1:0] s);
    logic [SYM_W-1:0] r;
    case (s)
      2'b00:   r = 2'b01;
      2'b01:   r = 2'b11;
      2'b11:   r = 2'b10;
      default: r = 2'b00;
    endcase
    return r;
  endfunction

  // Apply n steps (n = 0..3)
  function automatic logic [SYM_W-1:0] rot_n(input logic [SYM_W-1:0] s,
                                             input logic [1:0] n);
    logic [SYM_W-1:0] r;
    r = s;
    for (int i = 0; i < 3; i++) begin
      if (2'(i) < n) r = rot_step(r);
    end
    return r;
  endfunction

endpackage

// File: rtl/uwdf_window.sv
module uwdf_window
  import uwdf_pkg::*;
#(
  parameter int UW_LEN = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift_en,
  input  logic                      flush,
  input  logic [SYM_W-1:0]          sym_in,
  output logic [UW_LEN*SYM_W-1:0]   cand,
  output logic                      ready
);
  localparam int WIN_W  = UW_LEN * SYM_W;
  localparam int FILL_W = $clog2(UW_LEN + 1);

  logic [WIN_W-1:0]  win_q, win_d;
  logic [FILL_W-1:0] fill_q, fill_d;

  // Candidate window including the symbol arriving this cycle
  assign cand  = {win_q[WIN_W-SYM_W-1:0], sym_in};
  assign ready = (fill_q >= FILL_W'(UW_LEN - 1));

  always_comb begin
    win_d  = win_q;
    fill_d = fill_q;
    if (flush) begin
      fill_d = '0;
    end else if (shift_en) begin
      win_d = cand;
      if (fill_q != FILL_W'(UW_LEN)) fill_d = fill_q + FILL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else begin
      win_q  <= win_d;
      fill_q <= fill_d;
    end
  end

endmodule

// File: rtl/uwdf_matcher.sv
module uwdf_matcher
  import uwdf_pkg::*;
#(
  parameter int                       UW_LEN  = 8,
  parameter logic [UW_LEN*SYM_W-1:0]  UW_WORD = 16'hEB90
) (
  input  logic [UW_LEN*SYM_W-1:0] cand,
  output logic                    hit,
  output logic [1:0]              hit_rot
);
  localparam int WIN_W   = UW_LEN * SYM_W;
  localparam int NUM_ROT = 4;

  logic [WIN_W-1:0]   rot_word [NUM_ROT];
  logic [NUM_ROT-1:0] hit_vec;

  for (genvar k = 0; k < NUM_ROT; k++) begin : g_rot
    for (genvar i = 0; i < UW_LEN; i++) begin : g_sym
      assign rot_word[k][i*SYM_W +: SYM_W] = rot_n(UW_WORD[i*SYM_W +: SYM_W], 2'(k));
    end
    assign hit_vec[k] = (cand == rot_word[k]);
  end

  always_comb begin
    hit_rot = 2'd0;
    for (int k = NUM_ROT - 1; k >= 0; k--) begin
      if (hit_vec[k]) hit_rot = 2'(k);
    end
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/uwdf_packer.sv
module uwdf_packer
  import uwdf_pkg::*;
#(
  parameter int CHAR_W = 7,
  parameter int CHARS  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              sym_en,
  input  logic [SYM_W-1:0]  sym_in,
  input  logic [1:0]        rot,
  output logic              char_valid,
  output logic [CHAR_W-1:0] char_data,
  output logic              packet_done
);
  localparam int BC_W = $clog2(CHAR_W);
  localparam int CC_W = $clog2(CHARS + 1);

  logic [CHAR_W-1:0] acc_q, acc_d;
  logic [BC_W-1:0]   bcnt_q, bcnt_d;
  logic [CC_W-1:0]   ccnt_q, ccnt_d;
  logic [CHAR_W-1:0] emit_data, data_q;
  logic              emit, last;
  logic              valid_q, done_q;
  logic [1:0]        inv_rot;
  logic [SYM_W-1:0]  fixed;

  assign inv_rot = 2'd0 - rot;
  assign fixed   = rot_n(sym_in, inv_rot);

  always_comb begin
    acc_d     = acc_q;
    bcnt_d    = bcnt_q;
    emit      = 1'b0;
    emit_data = '0;
    for (int b = SYM_W - 1; b >= 0; b--) begin
      acc_d = {acc_d[CHAR_W-2:0], fixed[b]};
      if (bcnt_d == BC_W'(CHAR_W - 1)) begin
        emit      = 1'b1;
        emit_data = acc_d;
        bcnt_d    = '0;
      end else begin
        bcnt_d = bcnt_d + BC_W'(1);
      end
    end
    last   = emit && (ccnt_q == CC_W'(CHARS - 1));
    ccnt_d = ccnt_q;
    if (emit) ccnt_d = last ? '0 : ccnt_q + CC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      bcnt_q  <= '0;
      ccnt_q  <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= sym_en && !clr && emit;
      done_q  <= sym_en && !clr && last;
      if (clr) begin
        acc_q  <= '0;
        bcnt_q <= '0;
        ccnt_q <= '0;
      end else if (sym_en) begin
        acc_q  <= acc_d;
        bcnt_q <= bcnt_d;
        ccnt_q <= ccnt_d;
        if (emit) data_q <= emit_data;
      end
    end
  end

  assign char_valid  = valid_q;
  assign char_data   = data_q;
  assign packet_done = done_q;

endmodule

// File: rtl/uw_rotation_deframer.sv
module uw_rotation_deframer
  import uwdf_pkg::*;
#(
  parameter int                      UW_LEN   = 8,
  parameter int                      PAY_SYMS = 84,
  parameter int                      CHAR_W   = 7,
  parameter logic [UW_LEN*SYM_W-1:0] UW_WORD  = 16'hEB90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_valid,
  input  logic [1:0]        sym_in,
  output logic              frame_start,
  output logic [1:0]        rot_idx,
  output logic              char_valid,
  output logic [CHAR_W-1:0] char_data,
  output logic              packet_done
);
  localparam int WIN_W = UW_LEN * SYM_W;
  localparam int CHARS = (PAY_SYMS * SYM_W) / CHAR_W;
  localparam int PC_W  = $clog2(PAY_SYMS);

  uwdf_state_t       st_q, st_d;
  logic [PC_W-1:0]   pcnt_q, pcnt_d;
  logic [1:0]        rot_q, rot_d;
  logic              fs_q;
  logic [WIN_W-1:0]  cand;
  logic              win_ready, hit, take, pay_en, pay_last;
  logic [1:0]        hit_rot;

  uwdf_window #(.UW_LEN(UW_LEN)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (sym_valid && (st_q != ST_PAYLOAD)),
    .flush    (take || pay_last),
    .sym_in   (sym_in),
    .cand     (cand),
    .ready    (win_ready)
  );

  uwdf_matcher #(.UW_LEN(UW_LEN), .UW_WORD(UW_WORD)) u_match (
    .cand    (cand),
    .hit     (hit),
    .hit_rot (hit_rot)
  );

  assign take     = sym_valid && (st_q != ST_PAYLOAD) && win_ready && hit;
  assign pay_en   = sym_valid && (st_q == ST_PAYLOAD);
  assign pay_last = pay_en && (pcnt_q == PC_W'(PAY_SYMS - 1));

  always_comb begin
    st_d   = st_q;
    pcnt_d = pcnt_q;
    rot_d  = rot_q;
    case (st_q)
      ST_PAYLOAD: begin
        if (pay_last) begin
          st_d   = ST_RESYNC;
          pcnt_d = '0;
        end else if (pay_en) begin
          pcnt_d = pcnt_q + PC_W'(1);
        end
      end
      default: begin
        st_d = ST_SEARCH;
        if (take) begin
          st_d   = ST_PAYLOAD;
          pcnt_d = '0;
          rot_d  = hit_rot;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SEARCH;
      pcnt_q <= '0;
      rot_q  <= 2'd0;
      fs_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      pcnt_q <= pcnt_d;
      rot_q  <= rot_d;
      fs_q   <= take;
    end
  end

  uwdf_packer #(.CHAR_W(CHAR_W), .CHARS(CHARS)) u_pack (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (take),
    .sym_en      (pay_en),
    .sym_in      (sym_in),
    .rot         (rot_q),
    .char_valid  (char_valid),
    .char_data   (char_data),
    .packet_done (packet_done)
  );

  assign frame_start = fs_q;
  assign rot_idx     = rot_q;

endmodule

// File: rtl/uwdf_chk.sv
module uwdf_chk #(
  parameter int PAY_SYMS = 84,
  parameter int CHAR_W   = 7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sym_valid,
  input logic       frame_start,
  input logic       char_valid,
  input logic       packet_done,
  input logic [1:0] rot_idx
);
  localparam int CHARS = (PAY_SYMS * 2) / CHAR_W;
  localparam int CC_W  = $clog2(CHARS + 2);

  logic [CC_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (frame_start) seen_q <= '0;
    else if (char_valid && seen_q != CC_W'(CHARS + 1)) seen_q <= seen_q + CC_W'(1);
  end

  // R2
  fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R10
  rot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |-> $stable(rot_idx));

  // R6
  done_with_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    packet_done |-> char_valid);

  // R6
  char_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q <= CC_W'(CHARS));

  // R9
  char_needs_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> $past(sym_valid));

  // R9
  fs_needs_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(sym_valid));

  // R7
  no_fs_with_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> !frame_start);

endmodule

bind uw_rotation_deframer uwdf_chk #(.PAY_SYMS(PAY_SYMS), .CHAR_W(CHAR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sym_valid   (sym_valid),
  .frame_start (frame_start),
  .char_valid  (char_valid),
  .packet_done (packet_done),
  .rot_idx     (rot_idx)
);

// File: tb/sim_uw_rotation_deframer.sv
`timescale 1ns/1ps
module sim_uw_rotation_deframer;
  localparam logic [15:0] UWW = 16'hEB90;

  logic       clk, rst_n, sym_valid;
  logic [1:0] sym_in;
  logic       frame_start, char_valid, packet_done;
  logic [1:0] rot_idx;
  logic [6:0] char_data;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] bwin = '0;

  uw_rotation_deframer u0 (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_in(sym_in),
    .frame_start(frame_start), .rot_idx(rot_idx), .char_valid(char_valid),
    .char_data(char_data), .packet_done(packet_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] rot1(input logic [1:0] s);
    case (s)
      2'b00: return 2'b01;
      2'b01: return 2'b11;
      2'b11: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] rotn(input logic [1:0] s, input int n);
    logic [1:0] r = s;
    for (int i = 0; i < n; i++) r = rot1(r);
    return r;
  endfunction

  function automatic logic [1:0] uw_sym(input int i);
    return UWW[15 - 2*i -: 2];
  endfunction

  function automatic logic [15:0] rot_uw(input int k);
    logic [15:0] w;
    for (int i = 0; i < 8; i++) w[15 - 2*i -: 2] = rotn(uw_sym(i), k);
    return w;
  endfunction

  function automatic bit bad_win(input logic [15:0] w);
    for (int j = 0; j < 4; j++) begin
      logic [15:0] r = rot_uw(j);
      if (w == r || w[13:0] == r[15:2]) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic step(input logic v, input logic [1:0] s);
    @(negedge clk);
    sym_valid = v;
    sym_in    = s;
    @(posedge clk);
    #1;
  endtask

  task automatic noise(input int n);
    for (int m = 0; m < n; m++) begin
      logic [1:0] s = 2'($urandom % 4);
      for (int t = 0; t < 4; t++) if (bad_win({bwin[13:0], s})) s = s + 2'd1;
      step(1'b1, s);
      bwin = {bwin[13:0], s};
      chk("R4", "frame_start on noise", frame_start, 0);
    end
  endtask

  task automatic send_uw(input int k);
    for (int i = 0; i < 8; i++) begin
      logic [1:0] s = rotn(uw_sym(i), k);
      step(1'b1, s);
      bwin = {bwin[13:0], s};
      chk(k == 0 ? "R2" : "R3", "frame_start in sync word", frame_start, (i == 7) ? 1 : 0);
    end
    chk("R3", "rot_idx", rot_idx, k);
  endtask

  task automatic send_payload(input int k, input bit embed, input bit force_last, input int gap_pct);
    logic [1:0] tx [84];
    logic [6:0] acc = '0;
    int bc = 0;
    int cidx = 0;
    for (int i = 0; i < 84; i++) tx[i] = 2'($urandom % 4);
    if (embed) for (int i = 0; i < 8; i++) tx[20 + i] = uw_sym(i);
    if (force_last) tx[83] = uw_sym(0);
    for (int i = 0; i < 84; i++) begin
      bit got = 0;
      logic [6:0] exp_c = '0;
      while (int'($urandom % 100) < gap_pct) begin
        step(1'b0, 2'($urandom % 4));
        chk("R9", "char_valid in gap", char_valid, 0);
        chk("R9", "frame_start in gap", frame_start, 0);
      end
      step(1'b1, rotn(tx[i], k));
      for (int b = 1; b >= 0; b--) begin
        acc = {acc[5:0], tx[i][b]};
        bc++;
        if (bc == 7) begin
          got = 1; exp_c = acc; bc = 0;
        end
      end
      chk("R5", "char_valid", char_valid, got);
      chk("R7", "frame_start in payload", frame_start, 0);
      if (got) begin
        chk("R5", "char_data", char_data, exp_c);
        chk("R6", "packet_done", packet_done, (cidx == 23) ? 1 : 0);
        cidx++;
      end else begin
        chk("R6", "packet_done idle", packet_done, 0);
      end
    end
    chk("R6", "characters per frame", cidx, 24);
    bwin = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sym_valid = 1'b0; sym_in = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "frame_start in reset", frame_start, 0);
    chk("R1", "char_valid in reset", char_valid, 0);
    chk("R1", "rot_idx in reset", rot_idx, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "packet_done after reset", packet_done, 0);
    chk("R1", "char_data after reset", char_data, 0);

    noise(20);
    send_uw(0);
    send_payload(0, 0, 0, 0);

    // R4: one wrong symbol must not match
    noise(5);
    for (int i = 0; i < 8; i++) begin
      logic [1:0] s = rotn(uw_sym(i), 1);
      if (i == 3) s = rot1(s);
      step(1'b1, s);
      bwin = {bwin[13:0], s};
      chk("R4", "frame_start corrupt word", frame_start, 0);
    end
    noise(3);

    // R11: incomplete copy then full word, with gaps (R9)
    for (int i = 0; i < 5; i++) begin
      step(1'b1, rotn(uw_sym(i), 1));
      bwin = {bwin[13:0], rotn(uw_sym(i), 1)};
      chk("R11", "frame_start partial prefix", frame_start, 0);
    end
    send_uw(1);
    send_payload(1, 0, 0, 30);

    // R7 embedded word, then R8 flush test
    noise(4);
    send_uw(2);
    send_payload(2, 1, 1, 0);
    for (int i = 1; i < 8; i++) begin
      step(1'b1, rotn(uw_sym(i), 2));
      bwin = {bwin[13:0], rotn(uw_sym(i), 2)};
      chk("R8", "frame_start after flush", frame_start, 0);
    end
    chk("R10", "rot_idx held after frame", rot_idx, 2);
    send_uw(2);
    send_payload(2, 0, 0, 10);

    // R8: back-to-back frames with changing rotation
    send_uw(3);
    send_payload(3, 0, 0, 0);
    send_uw(0);
    send_payload(0, 0, 0, 5);

    for (int p = 0; p < 4; p++) begin
      int k = int'($urandom % 4);
      noise(int'($urandom % 12));
      send_uw(k);
      send_payload(k, p[0], 0, 15);
    end

    step(1'b0, 2'b00);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule